// File: doc/BRIEF.md
# Beam Steering Array Controller

This controller sits beside a small cluster of cores, such as a 2x2 group, whose antennas are close enough to act as one small array. A core that wants a directional channel hands the controller a packet made of a destination row, a destination column and a payload. The controller compares that destination with its own grid position and sorts it into one of nine coarse directions: omnidirectional, the four compass directions, or one of the four diagonals. It then stores the packet and its direction in a short ingress queue. When the packet leaves the queue, the controller reads a beam table for that direction. It drives one 2-bit phase state to each antenna's phase shifter, and it presents the payload to the antennas selected by the entry's enable mask.

Ingress and egress both use a valid/ready handshake. A packet is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` goes low while the queue holds its full four entries, so the core must hold the packet, and no packet is ever dropped. A beam is offered while `out_valid` is high and is consumed on an edge where `out_ready` is high. While `out_ready` is low, every beam output stays frozen. Between beams the controller stays out of the way: no transmit enable is asserted, and the phase shifters keep their last state, which lets each core radiate alone through its own antenna.

The table can be rewritten at runtime through a plain write port. Software can also program a hold window with `hold_cycles`. While the window is open, every issued packet reuses the beam latched when the window opened, instead of looking up a new one for each packet.

Top module: `bf_array_ctrl`

## Requirements
- R1: After reset `out_valid` is 0, `ant_en` is all zeros, every 2-bit field of `ant_phase` is 0 (0 degrees), and `in_ready` is 1.
- R2: Antenna i takes its phase state from `ant_phase[2i+1:2i]`, coded 0=0, 1=90, 2=180, 3=270 degrees. The field is copied verbatim from the selected table entry, so one-sided end-fire on four elements is the vector 0x E4.
- R3: Rows grow southward and columns grow eastward. A smaller destination row means north and a larger one south. A larger destination column means east and a smaller one west. Both differing gives a diagonal. `out_dir` codes are 0 omni, 1 N, 2 S, 3 E, 4 W, 5 NE, 6 NW, 7 SE, 8 SW, and that code is the table index used.
- R4: A destination equal to the controller's own row and column selects the omnidirectional entry, index 0.
- R5: When the output stage is empty or being consumed, a packet accepted on edge k shows its beam on `out_valid`, `out_dir`, `ant_phase`, `ant_en` and `ant_data` after edge k+1. With `out_ready` held high, queued packets issue one per cycle.
- R6: The queue holds 4 packets. With the output stalled, exactly five packets are accepted: four in the queue and one in the output stage. `in_ready` then stays low, and the packets later issue in arrival order.
- R7: While `out_valid` is high and `out_ready` is low, `out_dir`, `ant_phase`, `ant_en` and `ant_data` hold their values.
- R8: While a beam is offered, `ant_en` equals the entry's 4-bit mask. Payload lane i (`ant_data[32i+31:32i]`) carries the payload when bit i is set and zero otherwise.
- R9: With no beam offered, `ant_en` is all zeros and `ant_phase` keeps the value of the last beam.
- R10: A table write with `tbl_we` high stores `tbl_phase` and `tbl_mask` at index `tbl_idx` when that index is 0 to 8. A write to indices 9 to 15 changes no entry. At reset every entry has phase 0 and mask 0xF.
- R11: If `hold_cycles` is nonzero when a packet issues with no window open, that packet's beam (direction, phase and mask) is latched and a window of `hold_cycles` cycles opens. Packets issued inside the window reuse the latched beam. A value of 0 gives a fresh lookup for every packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| self_row | input | 3 | Grid row of this controller |
| self_col | input | 3 | Grid column of this controller |
| hold_cycles | input | 16 | Beam hold window length in cycles, 0 for per-packet lookup |
| in_valid | input | 1 | Ingress packet valid |
| in_ready | output | 1 | Ingress queue can accept |
| in_dst_row | input | 3 | Destination row of the packet |
| in_dst_col | input | 3 | Destination column of the packet |
| in_data | input | 32 | Packet payload |
| tbl_we | input | 1 | Beam table write enable |
| tbl_idx | input | 4 | Beam table entry to write |
| tbl_phase | input | 8 | Phase vector to store, 2 bits per antenna |
| tbl_mask | input | 4 | Antenna enable mask to store |
| out_valid | output | 1 | A beam and payload are offered |
| out_ready | input | 1 | Transceivers take the offered beam |
| out_dir | output | 4 | Direction code of the offered beam |
| ant_phase | output | 8 | Phase shifter states, 2 bits per antenna |
| ant_en | output | 4 | Per-antenna transmit strobe |
| ant_data | output | 128 | Per-antenna payload lanes, 32 bits each |

## Verification
A packet accepted on one rising edge, with the output stage free, has its beam due after the following rising edge. The bench therefore drives on a falling edge and holds `in_valid` for one edge. It releases the packet on the next falling edge and samples every beam output at the falling edge after that. In the stalled-queue test the bench counts acceptances edge by edge, reading `in_ready` at the falling edge before each rising edge. When it then releases `out_ready`, it expects one new payload at each following falling edge. In the hold test the bench waits well past the programmed window before it expects a fresh lookup again.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int DIR_W    = 4;
  localparam int NUM_DIRS = 9;

  typedef enum logic [DIR_W-1:0] {
    BD_OMNI = 4'd0,
    BD_N    = 4'd1,
    BD_S    = 4'd2,
    BD_E    = 4'd3,
    BD_W    = 4'd4,
    BD_NE   = 4'd5,
    BD_NW   = 4'd6,
    BD_SE   = 4'd7,
    BD_SW   = 4'd8
  } beam_dir_e;
endpackage

// File: rtl/bf_dir_decide.sv
module bf_dir_decide
  import bf_pkg::*;
#(
  parameter int ROW_W = 3,
  parameter int COL_W = 3
) (
  input  logic [ROW_W-1:0] self_row,
  input  logic [COL_W-1:0] self_col,
  input  logic [ROW_W-1:0] dst_row,
  input  logic [COL_W-1:0] dst_col,
  output beam_dir_e        dir
);
  // vert: 0 same row, 1 north, 2 south; horz: 0 same column, 1 east, 2 west
  logic [1:0] vert, horz;

  always_comb begin
    if (dst_row < self_row)      vert = 2'd1;
    else if (dst_row > self_row) vert = 2'd2;
    else                         vert = 2'd0;

    if (dst_col > self_col)      horz = 2'd1;
    else if (dst_col < self_col) horz = 2'd2;
    else                         horz = 2'd0;

    unique case ({vert, horz})
      4'b0100: dir = BD_N;
      4'b1000: dir = BD_S;
      4'b0001: dir = BD_E;
      4'b0010: dir = BD_W;
      4'b0101: dir = BD_NE;
      4'b0110: dir = BD_NW;
      4'b1001: dir = BD_SE;
      4'b1010: dir = BD_SW;
      default: dir = BD_OMNI;
    endcase
  end
endmodule

// File: rtl/bf_ingress_fifo.sv
module bf_ingress_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_valid,
  output logic                         push_ready,
  input  logic [W-1:0]                 push_data,
  output logic                         pop_valid,
  input  logic                         pop_ready,
  output logic [W-1:0]                 pop_data,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign push_ready = (cnt < LW'(DEPTH));
  assign pop_valid  = (cnt != '0);
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop_valid && pop_ready;
  assign pop_data   = mem[rd_ptr];
  assign level      = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      unique case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/bf_beam_table.sv
module bf_beam_table
  import bf_pkg::*;
#(
  parameter int N_ANT = 4,
  parameter int PH_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [DIR_W-1:0]       widx,
  input  logic [N_ANT*PH_W-1:0]  wphase,
  input  logic [N_ANT-1:0]       wmask,
  input  logic [DIR_W-1:0]       ridx,
  output logic [N_ANT*PH_W-1:0]  rphase,
  output logic [N_ANT-1:0]       rmask
);
  localparam int VEC_W = N_ANT * PH_W;

  logic [VEC_W-1:0] ph_q [NUM_DIRS];
  logic [N_ANT-1:0] mk_q [NUM_DIRS];

  for (genvar g = 0; g < NUM_DIRS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ph_q[g] <= '0;
        mk_q[g] <= '1;
      end else if (we && (widx == DIR_W'(g))) begin
        ph_q[g] <= wphase;
        mk_q[g] <= wmask;
      end
    end
  end

  always_comb begin
    rphase = '0;
    rmask  = '0;
    for (int e = 0; e < NUM_DIRS; e++) begin
      if (ridx == DIR_W'(e)) begin
        rphase = ph_q[e];
        rmask  = mk_q[e];
      end
    end
  end
endmodule

// File: rtl/bf_array_ctrl.sv
module bf_array_ctrl
  import bf_pkg::*;
#(
  parameter int N_ANT   = 4,
  parameter int PH_W    = 2,
  parameter int ROW_W   = 3,
  parameter int COL_W   = 3,
  parameter int DATA_W  = 32,
  parameter int Q_DEPTH = 4,
  parameter int HOLD_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ROW_W-1:0]         self_row,
  input  logic [COL_W-1:0]         self_col,
  input  logic [HOLD_W-1:0]        hold_cycles,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [ROW_W-1:0]         in_dst_row,
  input  logic [COL_W-1:0]         in_dst_col,
  input  logic [DATA_W-1:0]        in_data,
  input  logic                     tbl_we,
  input  logic [3:0]               tbl_idx,
  input  logic [N_ANT*PH_W-1:0]    tbl_phase,
  input  logic [N_ANT-1:0]         tbl_mask,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [3:0]               out_dir,
  output logic [N_ANT*PH_W-1:0]    ant_phase,
  output logic [N_ANT-1:0]         ant_en,
  output logic [N_ANT*DATA_W-1:0]  ant_data
);
  localparam int VEC_W = N_ANT * PH_W;
  localparam int ENT_W = DIR_W + DATA_W;
  localparam int LVL_W = $clog2(Q_DEPTH+1);

  // Stage 1: direction decided on the way into the queue
  beam_dir_e in_dir;

  bf_dir_decide #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dec (
    .self_row (self_row),
    .self_col (self_col),
    .dst_row  (in_dst_row),
    .dst_col  (in_dst_col),
    .dir      (in_dir)
  );

  logic [ENT_W-1:0] q_head;
  logic             q_valid;
  logic             q_pop;
  logic [LVL_W-1:0] q_level;

  bf_ingress_fifo #(.W(ENT_W), .DEPTH(Q_DEPTH)) u_q (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (in_valid),
    .push_ready (in_ready),
    .push_data  ({in_dir, in_data}),
    .pop_valid  (q_valid),
    .pop_ready  (q_pop),
    .pop_data   (q_head),
    .level      (q_level)
  );

  logic [DIR_W-1:0]  head_dir;
  logic [DATA_W-1:0] head_data;
  assign head_dir  = q_head[ENT_W-1 -: DIR_W];
  assign head_data = q_head[DATA_W-1:0];

  // Stage 2: table lookup and shifter drive
  logic [VEC_W-1:0] tbl_rphase;
  logic [N_ANT-1:0] tbl_rmask;

  bf_beam_table #(.N_ANT(N_ANT), .PH_W(PH_W)) u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (tbl_we),
    .widx   (tbl_idx),
    .wphase (tbl_phase),
    .wmask  (tbl_mask),
    .ridx   (head_dir),
    .rphase (tbl_rphase),
    .rmask  (tbl_rmask)
  );

  logic              vld_q;
  logic [DIR_W-1:0]  dir_q;
  logic [VEC_W-1:0]  ph_q;
  logic [N_ANT-1:0]  mk_q;
  logic [DATA_W-1:0] dat_q;
  logic              load;

  assign load  = q_valid && (!vld_q || out_ready);
  assign q_pop = load;

  // Hold window: reuse the latched beam while the counter runs
  logic [HOLD_W-1:0] hold_cnt;
  logic [DIR_W-1:0]  lat_dir;
  logic [VEC_W-1:0]  lat_ph;
  logic [N_ANT-1:0]  lat_mk;
  logic              use_lat;
  logic [DIR_W-1:0]  sel_dir;
  logic [VEC_W-1:0]  sel_ph;
  logic [N_ANT-1:0]  sel_mk;

  assign use_lat = (hold_cnt != '0);
  assign sel_dir = use_lat ? lat_dir : head_dir;
  assign sel_ph  = use_lat ? lat_ph  : tbl_rphase;
  assign sel_mk  = use_lat ? lat_mk  : tbl_rmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      lat_dir  <= '0;
      lat_ph   <= '0;
      lat_mk   <= '0;
    end else if (load && !use_lat) begin
      hold_cnt <= hold_cycles;
      lat_dir  <= head_dir;
      lat_ph   <= tbl_rphase;
      lat_mk   <= tbl_rmask;
    end else if (use_lat) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dir_q <= '0;
      ph_q  <= '0;
      mk_q  <= '0;
      dat_q <= '0;
    end else if (load) begin
      vld_q <= 1'b1;
      dir_q <= sel_dir;
      ph_q  <= sel_ph;
      mk_q  <= sel_mk;
      dat_q <= head_data;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_dir   = dir_q;
  assign ant_phase = ph_q;
  assign ant_en    = vld_q ? mk_q : '0;

  for (genvar a = 0; a < N_ANT; a++) begin : g_lane
    assign ant_data[a*DATA_W +: DATA_W] = ant_en[a] ? dat_q : '0;
  end
endmodule

// File: rtl/bf_array_ctrl_chk.sv
module bf_array_ctrl_chk #(
  parameter int N_ANT   = 4,
  parameter int PH_W    = 2,
  parameter int DATA_W  = 32,
  parameter int Q_DEPTH = 4,
  parameter int LVL_W   = $clog2(Q_DEPTH+1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [3:0]              out_dir,
  input logic [N_ANT*PH_W-1:0]   ant_phase,
  input logic [N_ANT-1:0]        ant_en,
  input logic [N_ANT*DATA_W-1:0] ant_data,
  input logic [LVL_W-1:0]        q_level
);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= LVL_W'(Q_DEPTH));

  // R6
  accept_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (q_level != '0) || out_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dir) && $stable(ant_phase)
                                   && $stable(ant_en) && $stable(ant_data)));

  // R9
  phase_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ant_phase) |-> out_valid);

  // R9
  fall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (ant_en == '0) && $stable(ant_phase));

  // R5
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(q_level) != '0));
endmodule

bind bf_array_ctrl bf_array_ctrl_chk #(
  .N_ANT   (N_ANT),
  .PH_W    (PH_W),
  .DATA_W  (DATA_W),
  .Q_DEPTH (Q_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_dir   (out_dir),
  .ant_phase (ant_phase),
  .ant_en    (ant_en),
  .ant_data  (ant_data),
  .q_level   (q_level)
);

// File: tb/bf_array_ctrl_tb_top.sv
`timescale 1ns/1ps
module bf_array_ctrl_tb_top;
  localparam int N_ANT  = 4;
  localparam int DW     = 32;
  localparam int PERIOD = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        self_row = 3'd3, self_col = 3'd3;
  logic [15:0]       hold_cycles = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [2:0]        in_dst_row = '0, in_dst_col = '0;
  logic [DW-1:0]     in_data = '0;
  logic              tbl_we = 1'b0;
  logic [3:0]        tbl_idx = '0;
  logic [7:0]        tbl_phase = '0;
  logic [3:0]        tbl_mask = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [3:0]        out_dir;
  logic [7:0]        ant_phase;
  logic [3:0]        ant_en;
  logic [N_ANT*DW-1:0] ant_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  bf_array_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .self_row(self_row), .self_col(self_col),
    .hold_cycles(hold_cycles), .in_valid(in_valid), .in_ready(in_ready),
    .in_dst_row(in_dst_row), .in_dst_col(in_dst_col), .in_data(in_data),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_phase(tbl_phase), .tbl_mask(tbl_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_dir(out_dir),
    .ant_phase(ant_phase), .ant_en(ant_en), .ant_data(ant_data)
  );

  // {self_row, self_col, dst_row, dst_col, expected direction}
  localparam logic [15:0] VECS [12] = '{
    {3'd3, 3'd3, 3'd3, 3'd3, 4'd0},
    {3'd3, 3'd3, 3'd1, 3'd3, 4'd1},
    {3'd3, 3'd3, 3'd6, 3'd3, 4'd2},
    {3'd3, 3'd3, 3'd3, 3'd5, 4'd3},
    {3'd3, 3'd3, 3'd3, 3'd0, 4'd4},
    {3'd3, 3'd3, 3'd0, 3'd7, 4'd5},
    {3'd3, 3'd3, 3'd2, 3'd2, 4'd6},
    {3'd3, 3'd3, 3'd4, 3'd4, 4'd7},
    {3'd3, 3'd3, 3'd7, 3'd0, 4'd8},
    {3'd3, 3'd3, 3'd3, 3'd4, 4'd3},
    {3'd0, 3'd0, 3'd0, 3'd0, 4'd0},
    {3'd7, 3'd7, 3'd0, 3'd7, 4'd1}
  };

  function automatic logic [7:0] ph_of(int d);
    return 8'(d * 37 + 5);
  endfunction

  function automatic logic [3:0] mk_of(int d);
    return 4'(d + 1);
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_beam(string req, logic [3:0] d, logic [7:0] ph, logic [3:0] mk,
                             logic [DW-1:0] dat);
    logic [N_ANT*DW-1:0] exp_data;
    exp_data = '0;
    for (int i = 0; i < N_ANT; i++) if (mk[i]) exp_data[i*DW +: DW] = dat;
    check(out_valid === 1'b1, req, 128'(out_valid), 128'(1));
    check({out_dir, ant_phase, ant_en} === {d, ph, mk}, req,
          128'({out_dir, ant_phase, ant_en}), 128'({d, ph, mk}));
    check(ant_data === exp_data, req, 128'(ant_data), 128'(exp_data));
  endtask

  task automatic wr_tbl(logic [3:0] idx, logic [7:0] ph, logic [3:0] mk);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = idx; tbl_phase = ph; tbl_mask = mk;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // drive one packet; returns at the falling edge where its beam is due
  task automatic send_one(logic [2:0] sr, logic [2:0] sc, logic [2:0] dr, logic [2:0] dc,
                          logic [DW-1:0] dat);
    @(negedge clk);
    self_row = sr; self_col = sc;
    in_valid = 1'b1; in_dst_row = dr; in_dst_col = dc; in_data = dat;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int acc;
    int nxt;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({out_valid, ant_en, ant_phase, in_ready} === {1'b0, 4'h0, 8'h00, 1'b1}, "R1",
          128'({out_valid, ant_en, ant_phase, in_ready}), 128'({1'b0, 4'h0, 8'h00, 1'b1}));
    rst_n = 1'b1;
    @(negedge clk);
    check({out_valid, ant_en, ant_phase} === 13'h0, "R1",
          128'({out_valid, ant_en, ant_phase}), 128'(0));

    // R10 reset table contents: phase 0, mask all ones
    send_one(3'd3, 3'd3, 3'd1, 3'd3, 32'hA5A5_0001);
    expect_beam("R10", 4'd1, 8'h00, 4'hF, 32'hA5A5_0001);

    for (int d = 0; d < 9; d++) wr_tbl(4'(d), ph_of(d), mk_of(d));

    // R3 R4 R2 R8 R5: vector table walk
    for (int v = 0; v < 12; v++) begin
      logic [15:0] e;
      e = VECS[v];
      send_one(e[15:13], e[12:10], e[9:7], e[6:4], 32'h1000 + 32'(v));
      expect_beam((e[3:0] == 4'd0) ? "R4" : "R3", e[3:0], ph_of(int'(e[3:0])),
                  mk_of(int'(e[3:0])), 32'h1000 + 32'(v));
    end

    // R10 out-of-range index must not alias onto entry 1
    wr_tbl(4'd9, 8'hFF, 4'h0);
    send_one(3'd3, 3'd3, 3'd0, 3'd3, 32'h0BAD_0009);
    expect_beam("R10", 4'd1, ph_of(1), mk_of(1), 32'h0BAD_0009);

    // R2 one-sided end-fire vector 0,90,180,270
    wr_tbl(4'd3, 8'hE4, 4'hF);
    send_one(3'd3, 3'd3, 3'd3, 3'd6, 32'hE4E4_0003);
    expect_beam("R2", 4'd3, 8'hE4, 4'hF, 32'hE4E4_0003);

    // R6 R7 queue fill with output stalled
    @(negedge clk);
    out_ready = 1'b0;
    acc = 0;
    nxt = 1;
    for (int c = 0; c < 8; c++) begin
      in_valid = 1'b1; in_dst_row = 3'd1; in_dst_col = 3'd3; in_data = 32'(nxt);
      if (in_ready) begin
        acc++;
        nxt++;
      end
      @(negedge clk);
      if (c >= 1) expect_beam("R7", 4'd1, ph_of(1), mk_of(1), 32'd1);
    end
    in_valid = 1'b0;
    check(acc == 5, "R6", 128'(acc), 128'(5));
    check(in_ready === 1'b0, "R6", 128'(in_ready), 128'(0));

    // R5 R6 drain: one per cycle in arrival order
    out_ready = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      expect_beam("R6", 4'd1, ph_of(1), mk_of(1), 32'(k));
      @(negedge clk);
    end
    // R9 idle: no strobe, phase retained
    check({out_valid, ant_en} === 5'h0, "R9", 128'({out_valid, ant_en}), 128'(0));
    check(ant_phase === ph_of(1), "R9", 128'(ant_phase), 128'(ph_of(1)));
    repeat (3) @(negedge clk);
    check(ant_phase === ph_of(1) && ant_en === 4'h0, "R9",
          128'({ant_phase, ant_en}), 128'({ph_of(1), 4'h0}));

    // R11 hold window
    hold_cycles = 16'd20;
    @(negedge clk);
    in_valid = 1'b1; in_dst_row = 3'd1; in_dst_col = 3'd3; in_data = 32'h51;
    @(negedge clk);
    in_dst_row = 3'd6; in_data = 32'h52;
    @(negedge clk);
    in_valid = 1'b0;
    expect_beam("R11", 4'd1, ph_of(1), mk_of(1), 32'h51);
    @(negedge clk);
    expect_beam("R11", 4'd1, ph_of(1), mk_of(1), 32'h52);
    repeat (30) @(negedge clk);
    send_one(3'd3, 3'd3, 3'd6, 3'd3, 32'h53);
    expect_beam("R11", 4'd2, ph_of(2), mk_of(2), 32'h53);
    hold_cycles = 16'd0;
    repeat (30) @(negedge clk);
    send_one(3'd3, 3'd3, 3'd3, 3'd0, 32'h54);
    expect_beam("R11", 4'd4, ph_of(4), mk_of(4), 32'h54);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule